// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers up to eight interrupt request lines into one interrupt output toward a processor. Software programs it through two write addresses. Address A starts a programming sequence and also takes the end-of-interrupt command. Address B takes the remaining setup words and, once setup is finished, the line mask. The controller stays silent until its setup sequence ends. The sequence is three, four or two words long, depending on whether cascading and the optional fourth word were selected in the first word.

When the processor acknowledges the interrupt, the controller picks the highest-priority pending unmasked line. Line 0 is the highest priority. The controller marks that line as in service and returns, for one cycle, a vector made of a programmed base and the line number. A serviced line holds off that line and every lower-priority line. It is retired either by writing the end-of-interrupt command or, when automatic completion is programmed, at the moment of the acknowledge. Cascade wiring is kept only as a stored configuration value.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, `int_out`, `vec_valid` and `init_done` are all 0.
- R2: A write to address A (`wr_sel`=0) with bit 4 set begins setup. The next address-B word is the base. A cascade word follows only when bit 1 of the first word is 0. A mode word follows only when bit 0 of the first word is 1. `init_done` rises after the last expected word.
- R3: When cascading is selected, the cascade word is presented unchanged on `casc_cfg`. A setup run without that word leaves `casc_cfg` at 0.
- R4: The low five bits of the mode word appear on `mode_cfg`. Bit 1 of the mode word selects automatic completion. A setup run without a mode word leaves `mode_cfg` at 0.
- R5: An acknowledge while `int_out` is 1 gives `vec_valid`=1 in the next cycle, for one cycle only. At that point `vec_out` equals base bits 7..3 with the granted line number in bits 2..0.
- R6: After setup, an address-B write loads the mask. A line whose mask bit is 1 never raises `int_out` and is never granted.
- R7: Of several pending lines, the lowest-numbered one is granted first.
- R8: With manual completion, an in-service line blocks itself and all higher-numbered lines. Writing 0x20 to address A retires only the lowest-numbered in-service line.
- R9: A pending line numbered lower than every in-service line raises `int_out`.
- R10: With automatic completion, no line stays in service after its acknowledge.
- R11: With bit 3 of the first word at 0, a request is captured on a rising input, and a held-high input does not request again. With bit 3 at 1, the request follows the input level.
- R12: Starting setup again clears the mask, the in-service state and the pending requests, and drops `int_out` until the new setup ends.
- R13: Before setup ends, `int_out` stays 0 and an acknowledge produces no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = address A, 1 = address B |
| wr_data | input | 8 | Write data |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec_out | output | 8 | Interrupt vector |
| init_done | output | 1 | Setup sequence complete |
| casc_cfg | output | 8 | Stored cascade word |
| mode_cfg | output | 5 | Stored mode word bits 4..0 |

## Verification
A corrupted in-service register shows up at once on `int_out`. A bit left set silences lines that should interrupt. A missing bit lets a same-priority request re-raise the output in the cycle after the acknowledge. A wrong setup-step register shows in the `init_done` timing and on the configuration outputs in the cycle after the offending write. A wrong mask or priority choice appears in the vector one cycle after the acknowledge. The scoreboard then compares that vector against the line the requirements predict.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [2:0] {
      ST_UNINIT,
      ST_ICW2,
      ST_ICW3,
      ST_ICW4,
      ST_READY
   } pic_state_e;

   localparam int SETUP_MARK_BIT  = 4;
   localparam int SETUP_LEVEL_BIT = 3;
   localparam int SETUP_SOLO_BIT  = 1;
   localparam int SETUP_HAS4_BIT  = 0;
   localparam int MODE_AUTO_BIT   = 1;
   localparam int MODE_W          = 5;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES = 8,
   parameter int BASE_W = 5,
   parameter logic [DATA_W-1:0] EOI_CMD = 8'h20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               ready,
   output logic               init_start,
   output logic               eoi_cmd,
   output logic               level_mode,
   output logic [BASE_W-1:0]  base,
   output logic [LINES-1:0]   casc,
   output logic [MODE_W-1:0]  mode,
   output logic [LINES-1:0]   mask
);
   pic_state_e state_q;
   logic       solo_q;
   logic       has4_q;
   logic       wr_b;

   always_comb begin
      init_start = wr_en && !wr_sel && wr_data[SETUP_MARK_BIT];
      eoi_cmd    = wr_en && !wr_sel && (state_q == ST_READY) && (wr_data == EOI_CMD);
      wr_b       = wr_en && wr_sel;
      ready      = (state_q == ST_READY);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_UNINIT;
         solo_q     <= 1'b0;
         has4_q     <= 1'b0;
         level_mode <= 1'b0;
         base       <= '0;
         casc       <= '0;
         mode       <= '0;
         mask       <= '1;
      end else if (init_start) begin
         level_mode <= wr_data[SETUP_LEVEL_BIT];
         solo_q     <= wr_data[SETUP_SOLO_BIT];
         has4_q     <= wr_data[SETUP_HAS4_BIT];
         casc       <= '0;
         mode       <= '0;
         mask       <= '0;
         state_q    <= ST_ICW2;
      end else if (wr_b) begin
         case (state_q)
            ST_ICW2: begin
               base    <= wr_data[DATA_W-1 -: BASE_W];
               state_q <= !solo_q ? ST_ICW3 : (has4_q ? ST_ICW4 : ST_READY);
            end
            ST_ICW3: begin
               casc    <= wr_data[LINES-1:0];
               state_q <= has4_q ? ST_ICW4 : ST_READY;
            end
            ST_ICW4: begin
               mode    <= wr_data[MODE_W-1:0];
               state_q <= ST_READY;
            end
            ST_READY: mask <= wr_data[LINES-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pic_req_cell.sv
module pic_req_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic enable,
   input  logic level_mode,
   input  logic irq,
   input  logic granted,
   output logic req
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         req    <= 1'b0;
      end else begin
         prev_q <= irq;
         if (flush || !enable) req <= 1'b0;
         else if (level_mode)  req <= irq;
         else                  req <= (req && !granted) || (irq && !prev_q);
      end
   end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
   parameter int LINES = 8,
   parameter int ID_W = 3,
   parameter int BASE_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ready,
   input  logic                    flush,
   input  logic                    eoi_cmd,
   input  logic                    auto_eoi,
   input  logic                    int_ack,
   input  logic [LINES-1:0]        req,
   input  logic [LINES-1:0]        mask,
   input  logic [BASE_W-1:0]       base,
   output logic                    int_out,
   output logic [LINES-1:0]        grant_vec,
   output logic [LINES-1:0]        isr,
   output logic                    vec_valid,
   output logic [BASE_W+ID_W-1:0]  vec_out
);
   logic [LINES-1:0] pend;
   logic [LINES-1:0] isr_nxt;
   logic [ID_W-1:0]  hp_idx, hs_idx;
   logic             hp_any, hs_any, grant;

   always_comb begin
      pend   = req & ~mask;
      hp_idx = '0;
      hp_any = 1'b0;
      hs_idx = '0;
      hs_any = 1'b0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (pend[i]) begin
            hp_idx = ID_W'(i);
            hp_any = 1'b1;
         end
         if (isr[i]) begin
            hs_idx = ID_W'(i);
            hs_any = 1'b1;
         end
      end
      int_out   = ready && hp_any && (!hs_any || (hp_idx < hs_idx));
      grant     = int_ack && int_out;
      grant_vec = grant ? (LINES'(1) << hp_idx) : '0;
      isr_nxt   = isr;
      if (eoi_cmd && hs_any) isr_nxt[hs_idx] = 1'b0;
      if (grant && !auto_eoi) isr_nxt[hp_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr       <= '0;
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= grant;
         if (grant) vec_out <= {base, hp_idx};
         isr <= flush ? '0 : isr_nxt;
      end
   end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
   import pic_pkg::*;
#(
   parameter int LINES = 8,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] EOI_CMD = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LINES-1:0]  irq_in,
   input  logic              int_ack,
   output logic              int_out,
   output logic              vec_valid,
   output logic [DATA_W-1:0] vec_out,
   output logic              init_done,
   output logic [LINES-1:0]  casc_cfg,
   output logic [MODE_W-1:0] mode_cfg
);
   localparam int ID_W   = $clog2(LINES);
   localparam int BASE_W = DATA_W - ID_W;

   if (LINES != 8) begin : g_bad_lines
      $error("irq_ctrl8: LINES must be 8 to match the cascade bitmap word");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("irq_ctrl8: DATA_W must be 8 to match the setup word layout");
   end

   logic              ready, init_start, eoi_cmd, level_mode;
   logic [BASE_W-1:0] base;
   logic [LINES-1:0]  mask_w, req_w, grant_w, isr_w;

   pic_init_seq #(
      .DATA_W(DATA_W), .LINES(LINES), .BASE_W(BASE_W), .EOI_CMD(EOI_CMD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ready(ready), .init_start(init_start), .eoi_cmd(eoi_cmd),
      .level_mode(level_mode), .base(base), .casc(casc_cfg), .mode(mode_cfg),
      .mask(mask_w)
   );

   for (genvar g = 0; g < LINES; g++) begin : g_line
      pic_req_cell u_cell (
         .clk(clk), .rst_n(rst_n), .flush(init_start), .enable(ready),
         .level_mode(level_mode), .irq(irq_in[g]), .granted(grant_w[g]),
         .req(req_w[g])
      );
   end

   pic_service #(
      .LINES(LINES), .ID_W(ID_W), .BASE_W(BASE_W)
   ) u_svc (
      .clk(clk), .rst_n(rst_n), .ready(ready), .flush(init_start),
      .eoi_cmd(eoi_cmd), .auto_eoi(mode_cfg[MODE_AUTO_BIT]), .int_ack(int_ack),
      .req(req_w), .mask(mask_w), .base(base), .int_out(int_out),
      .grant_vec(grant_w), .isr(isr_w), .vec_valid(vec_valid), .vec_out(vec_out)
   );

   assign init_done = ready;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
   parameter int LINES = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              int_ack,
   input logic              int_out,
   input logic              vec_valid,
   input logic [DATA_W-1:0] vec_out,
   input logic              init_done,
   input logic              auto_eoi,
   input logic              eoi_cmd,
   input logic [LINES-1:0]  mask_q,
   input logic [LINES-1:0]  isr_q
);
   localparam int ID_W = $clog2(LINES);
   logic [LINES-1:0] mask_d;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_d <= '1;
      else        mask_d <= mask_q;
   end

   p_vec_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && int_out |=> vec_valid);
   p_vec_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(int_ack && int_out));
   p_quiet_uninit_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !int_out);
   p_vec_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> !mask_d[vec_out[ID_W-1:0]]);
   p_auto_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done && auto_eoi |-> isr_q == '0);
   p_eoi_retires_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_cmd && !int_ack && (isr_q != '0)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

bind irq_ctrl8 pic_chk #(.LINES(LINES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_out(int_out),
   .vec_valid(vec_valid), .vec_out(vec_out), .init_done(init_done),
   .auto_eoi(mode_cfg[1]), .eoi_cmd(eoi_cmd), .mask_q(mask_w), .isr_q(isr_w)
);

// File: tb/irq_ctrl8_tb_top.sv
module irq_ctrl8_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] irq_in = '0;
   logic       int_ack = 1'b0;
   logic       int_out, vec_valid, init_done;
   logic [7:0] vec_out, casc_cfg;
   logic [4:0] mode_cfg;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   irq_ctrl8 dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq_in(irq_in), .int_ack(int_ack), .int_out(int_out), .vec_valid(vec_valid),
      .vec_out(vec_out), .init_done(init_done), .casc_cfg(casc_cfg), .mode_cfg(mode_cfg)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_irq(logic [7:0] v);
      irq_in = v;
      @(negedge clk);
   endtask

   // driver: pushes the expected vector (or none if negative)
   task automatic ack(int exp);
      int_ack = 1'b1;
      if (exp >= 0) exp_q.push_back(exp);
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   // monitor: pops and compares each produced vector
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R13 unexpected vector actual=%0h expected=none", vec_out);
         end else begin
            chk("R5 vector", int'(vec_out), exp_q.pop_front());
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 int_out", int_out, 0);
      chk("R1 vec_valid", vec_valid, 0);
      chk("R1 init_done", init_done, 0);

      // R13: silent before setup
      set_irq(8'h01);
      chk("R13 int_out before setup", int_out, 0);
      ack(-1);
      chk("R13 no vector before setup", vec_valid, 0);
      set_irq(8'h00);

      // R2/R3/R4: master setup, four words
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h04);
      chk("R2 not done before mode word", init_done, 0);
      wr(1'b1, 8'h05);
      chk("R2 done after mode word", init_done, 1);
      chk("R3 cascade word", casc_cfg, 8'h04);
      chk("R4 mode word", mode_cfg, 5'h05);

      // R11 edge capture, R5 vector
      set_irq(8'h08);
      chk("R11 edge request", int_out, 1);
      ack(8'h23);
      chk("R8 own level blocked", int_out, 0);
      set_irq(8'h00);
      set_irq(8'h08);
      chk("R8 same line held off", int_out, 0);
      set_irq(8'h28);
      chk("R8 lower priority held off", int_out, 0);
      set_irq(8'h2A);
      chk("R9 higher priority nests", int_out, 1);
      ack(8'h21);
      chk("R9 both in service", int_out, 0);
      wr(1'b0, 8'h20);
      chk("R8 eoi retires only lowest line", int_out, 0);
      wr(1'b0, 8'h20);
      chk("R8 second eoi frees line 3", int_out, 1);
      ack(8'h23);
      chk("R8 line 5 waits", int_out, 0);
      wr(1'b0, 8'h20);
      chk("R8 line 5 released", int_out, 1);
      ack(8'h25);
      wr(1'b0, 8'h20);
      chk("R11 held input no re-request", int_out, 0);
      set_irq(8'h00);

      // R6 mask
      wr(1'b1, 8'h04);
      set_irq(8'h04);
      chk("R6 masked line silent", int_out, 0);
      set_irq(8'h44);
      chk("R6 unmasked line raises", int_out, 1);
      ack(8'h26);
      wr(1'b0, 8'h20);
      chk("R6 masked still silent", int_out, 0);
      wr(1'b1, 8'h00);
      chk("R6 unmask releases", int_out, 1);
      ack(8'h22);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // R7 fixed priority
      set_irq(8'h90);
      ack(8'h24);
      wr(1'b0, 8'h20);
      ack(8'h27);
      wr(1'b0, 8'h20);
      chk("R7 all served", int_out, 0);
      set_irq(8'h00);

      // R12 restart setup: slave values
      set_irq(8'h40);
      ack(8'h26);
      wr(1'b1, 8'hFF);
      wr(1'b0, 8'h11);
      chk("R12 setup restarted", init_done, 0);
      chk("R12 int_out dropped", int_out, 0);
      wr(1'b1, 8'h28);
      wr(1'b1, 8'h02);
      wr(1'b1, 8'h01);
      chk("R2 slave setup done", init_done, 1);
      chk("R3 slave cascade word", casc_cfg, 8'h02);
      chk("R4 slave mode word", mode_cfg, 5'h01);
      set_irq(8'h00);
      set_irq(8'h40);
      chk("R12 mask and service cleared", int_out, 1);
      ack(8'h2E);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // R2 two-word setup, no cascade, no mode word
      wr(1'b0, 8'h12);
      wr(1'b1, 8'h30);
      chk("R2 two-word setup done", init_done, 1);
      chk("R3 no cascade word", casc_cfg, 0);
      chk("R4 no mode word", mode_cfg, 0);
      set_irq(8'h01);
      ack(8'h30);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // level mode with automatic completion
      wr(1'b0, 8'h1B);
      wr(1'b1, 8'h40);
      chk("R2 three-word setup pending", init_done, 0);
      wr(1'b1, 8'h03);
      chk("R2 three-word setup done", init_done, 1);
      set_irq(8'h04);
      chk("R11 level request", int_out, 1);
      set_irq(8'h00);
      chk("R11 level request withdrawn", int_out, 0);
      set_irq(8'h24);
      ack(8'h42);
      chk("R10 auto completion re-raises", int_out, 1);
      ack(8'h42);
      set_irq(8'h20);
      ack(8'h45);
      set_irq(8'h00);
      cyc(1);
      chk("R11 level all low", int_out, 0);

      cyc(2);
      chk("R5 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule